// File: doc/BRIEF.md
# NAND Read-Retry Command Generator

This block produces the command stream that moves a NAND device's read thresholds to its next retry level. A controller first presents the device's manufacturer ID byte with a load strobe. The block maps that byte to one of four retry styles, each with its own level count, and clears its retry level. Every later step request makes the block emit the complete command sequence for the current level and then advance the level. The level wraps to zero when it reaches the maximum for the style. When the ID selects no style, retry is disabled and a step only completes.

Words leave on a valid/ready interface that feeds the same bus-phase engine as a page read. Each word carries a kind (command latch, address latch, data write, idle gap with a count, or wait-for-ready) and an 8-bit argument. Per-level threshold bytes come from small constant tables held in the design.

Top module: `rr_cmd_gen`

## Requirements
- R1: After reset, busy, word_valid and done are 0, word_kind is 0 and level is 0.
- R2: A load while idle selects the style from id_byte. 0x2C selects style A with 8 levels, 0x98 style B with 8, 0xEC style C with 15 and 0x45 style D with 22. Any other value disables retry (maximum 0).
- R3: Each completed sequence advances level by one. The level becomes 0 when the incremented value equals the style maximum.
- R4: Style A emits CMD EF, ADDR 89, IDLE 3, DATA level, three DATA 00, IDLE 2, WAIT. Word kinds are coded CMD=1, ADDR=2, DATA=3, IDLE=4 (the argument is the gap count) and WAIT=5.
- R5: Style C covers registers A7, A4, A5, A6 in that order. For each it emits CMD A1, ADDR 00, ADDR register, IDLE 2, DATA table value, IDLE 8. This gives 24 words.
- R6: Style B at level 0 first emits CMD 5C and CMD C5. At every level it writes registers 4, 5, 6 and 7 with their table bytes, then register 0D with 00. Each register write is CMD 55, IDLE 2, ADDR register, IDLE 2, DATA value.
- R7: Style B ends with CMD 26 and CMD 5D at levels 0 to 5. Level 6 inserts CMD B3 before those two words. Level 7 is the exit level: it writes zero data and ends with CMD FF, IDLE 2, WAIT.
- R8: Style D starts with CMD 3B, CMD B9. Level 0 then writes 00 to registers 4 to 12, each as CMD 54, ADDR register, DATA value. Levels 1 to 20 write table bytes to registers 4, 5 and 7. Level 21 writes 00 to registers 4, 5 and 7. The sequence ends with CMD D6 at level 21 and with CMD B6 at every other level.
- R9: While busy, step_req and id_load are ignored. The running sequence, the style and the level are unaffected.
- R10: With retry disabled, a step request raises done in the next cycle, emits no word and leaves level at 0.
- R11: While word_valid is high and word_ready is low, the word is held stable. Busy stays high until the last word is accepted. Done is a one-cycle pulse in the following cycle.
- R12: A load while idle resets level to 0. If load and step_req arrive in the same cycle, the load wins and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_load | input | 1 | Latch id_byte as the vendor selection |
| id_byte | input | 8 | Manufacturer ID byte |
| step_req | input | 1 | Request the next retry sequence |
| word_ready | input | 1 | Downstream accepts the current word |
| word_valid | output | 1 | A command word is presented |
| word_kind | output | 3 | Word kind code |
| word_arg | output | 8 | Opcode, address, data byte or idle count |
| busy | output | 1 | A sequence is being emitted |
| done | output | 1 | One-cycle completion pulse |
| level | output | 5 | Current retry level |

## Verification
The hardest states to reach are the deep levels: style B's extra-opcode level 6 and its exit level 7, and style D's exit level 21. Each of these appears only after every earlier sequence for that vendor has completed. The stimulus therefore steps each vendor through one full wrap, so every level's words are compared with a model. Downstream readiness is throttled on a fixed pattern so that words are also held under back-pressure. One sequence receives a step request and a vendor load partway through, to show that neither affects it.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int LVL_W = 5;
  localparam int IDX_W = 5;
  localparam int ARG_W = 8;

  localparam int MAX_A = 8;
  localparam int MAX_B = 8;
  localparam int MAX_C = 15;
  localparam int MAX_D = 22;
  localparam int EXIT_B = MAX_B - 1;
  localparam int EXIT_D = MAX_D - 1;
  localparam int B_EXTRA_LVL = 6;
  localparam int C_REGS = 4;
  localparam int C_PHASES = 6;
  localparam int B_PHASES = 5;
  localparam int B_REGS = 5;
  localparam int D_PHASES = 3;
  localparam int D_INIT_REGS = 9;
  localparam int D_REGS = 3;

  localparam logic [7:0] ID_A = 8'h2C;
  localparam logic [7:0] ID_B = 8'h98;
  localparam logic [7:0] ID_C = 8'hEC;
  localparam logic [7:0] ID_D = 8'h45;

  typedef enum logic [2:0] {
    STY_NONE = 3'd0, STY_A = 3'd1, STY_B = 3'd2, STY_C = 3'd3, STY_D = 3'd4
  } rr_style_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0, WK_CMD = 3'd1, WK_ADDR = 3'd2, WK_DATA = 3'd3,
    WK_IDLE = 3'd4, WK_WAIT = 3'd5
  } rr_kind_e;

  typedef struct packed {
    rr_kind_e         kind;
    logic [ARG_W-1:0] arg;
    logic             last;
  } rr_word_t;

  function automatic rr_word_t mk_word(rr_kind_e k, int a, logic l);
    rr_word_t w;
    w.kind = k;
    w.arg  = ARG_W'(a);
    w.last = l;
    return w;
  endfunction

  function automatic rr_style_e style_of_id(logic [7:0] id);
    case (id)
      ID_A:    return STY_A;
      ID_B:    return STY_B;
      ID_C:    return STY_C;
      ID_D:    return STY_D;
      default: return STY_NONE;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] style_max(rr_style_e s);
    case (s)
      STY_A:   return LVL_W'(MAX_A);
      STY_B:   return LVL_W'(MAX_B);
      STY_C:   return LVL_W'(MAX_C);
      STY_D:   return LVL_W'(MAX_D);
      default: return '0;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] next_level(logic [LVL_W-1:0] lvl,
                                                  logic [LVL_W-1:0] mx);
    logic [LVL_W-1:0] inc;
    inc = lvl + LVL_W'(1);
    return (inc == mx) ? '0 : inc;
  endfunction
endpackage

// File: rtl/rr_vendor_map.sv
module rr_vendor_map
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [7:0]       id_byte,
  output rr_style_e        style,
  output logic [LVL_W-1:0] max_lvl
);
  rr_style_e style_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       style_q <= STY_NONE;
    else if (load_en) style_q <= style_of_id(id_byte);
  end

  assign style   = style_q;
  assign max_lvl = style_max(style_q);

  // R2: after a load, the maximum is one of the legal level counts
  p_max_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (max_lvl == 0 || max_lvl == LVL_W'(MAX_A) ||
                 max_lvl == LVL_W'(MAX_C) || max_lvl == LVL_W'(MAX_D)));
endmodule

// File: rtl/rr_level_ctr.sv
module rr_level_ctr
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [LVL_W-1:0] max_lvl,
  output logic [LVL_W-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level <= '0;
    else if (clr) level <= '0;
    else if (adv) level <= next_level(level, max_lvl);
  end

  // R3: the level stays inside the vendor range
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (max_lvl != 0) |-> (level < max_lvl));

  // R3: an advance moves up by one or wraps to zero
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (level == 0 || level == $past(level) + LVL_W'(1)));
endmodule

// File: rtl/rr_seq_rom.sv
module rr_seq_rom
  import rr_pkg::*;
(
  input  rr_style_e        style,
  input  logic [LVL_W-1:0] level,
  input  logic [IDX_W-1:0] idx,
  output rr_word_t         word
);
  function automatic logic [7:0] tbl_b(int lv, int g);
    logic [31:0] row;
    case (lv)
      0:       row = 32'h04047C7E;
      1:       row = 32'h007C7878;
      2:       row = 32'h7C767472;
      3:       row = 32'h08080000;
      4:       row = 32'h0B7E7674;
      5:       row = 32'h10767270;
      6:       row = 32'h02007E7C;
      default: row = 32'h00000000;
    endcase
    return row[31-8*g -: 8];
  endfunction

  function automatic logic [7:0] tbl_c(int lv, int g);
    logic [31:0] row;
    case (lv)
      1:       row = 32'h050A0000;
      2:       row = 32'h2800ECD8;
      3:       row = 32'hEDF5EDE6;
      4:       row = 32'h0A0F0500;
      5:       row = 32'h0F0AFBEC;
      6:       row = 32'hE8EFE8DC;
      7:       row = 32'hF1FBFEF0;
      8:       row = 32'h0A00FBEC;
      9:       row = 32'hD0E2D0C2;
      10:      row = 32'h140FFBEC;
      11:      row = 32'hE8FBE8DC;
      12:      row = 32'h1E14FBEC;
      13:      row = 32'hFBFFFBF8;
      14:      row = 32'h070C0200;
      default: row = 32'h00000000;
    endcase
    return row[31-8*g -: 8];
  endfunction

  function automatic logic [7:0] tbl_d(int lv, int g);
    logic [23:0] row;
    case (lv)
      1:       row = 24'hF0F0F0;
      2:       row = 24'hEFE0E0;
      3:       row = 24'hDFD0D0;
      4:       row = 24'h1EE010;
      5:       row = 24'h2ED020;
      6:       row = 24'h3DF030;
      7:       row = 24'hCDE0D0;
      8:       row = 24'h0DD010;
      9:       row = 24'h011020;
      10:      row = 24'h122020;
      11:      row = 24'hB210D0;
      12:      row = 24'hA320D0;
      13:      row = 24'h9F00D0;
      14:      row = 24'hBEF0C0;
      15:      row = 24'hADC0C0;
      16:      row = 24'h9FF0C0;
      17:      row = 24'h010000;
      18:      row = 24'h020000;
      19:      row = 24'h0DB000;
      20:      row = 24'h0CA000;
      default: row = 24'h000000;
    endcase
    return row[23-8*g -: 8];
  endfunction

  // style A: feature write with the level as first parameter byte
  function automatic rr_word_t seq_a(int lv, int ix);
    case (ix)
      0:       return mk_word(WK_CMD, 'hEF, 1'b0);
      1:       return mk_word(WK_ADDR, 'h89, 1'b0);
      2:       return mk_word(WK_IDLE, 3, 1'b0);
      3:       return mk_word(WK_DATA, lv, 1'b0);
      4, 5, 6: return mk_word(WK_DATA, 0, 1'b0);
      7:       return mk_word(WK_IDLE, 2, 1'b0);
      default: return mk_word(WK_WAIT, 0, 1'b1);
    endcase
  endfunction

  // style C: four indirect register writes, fixed register order
  function automatic rr_word_t seq_c(int lv, int ix);
    int g, ph, rg;
    g  = ix / C_PHASES;
    ph = ix % C_PHASES;
    case (g)
      0:       rg = 'hA7;
      1:       rg = 'hA4;
      2:       rg = 'hA5;
      default: rg = 'hA6;
    endcase
    case (ph)
      0:       return mk_word(WK_CMD, 'hA1, 1'b0);
      1:       return mk_word(WK_ADDR, 0, 1'b0);
      2:       return mk_word(WK_ADDR, rg, 1'b0);
      3:       return mk_word(WK_IDLE, 2, 1'b0);
      4:       return mk_word(WK_DATA, int'(tbl_c(lv, g)), 1'b0);
      default: return mk_word(WK_IDLE, 8, ix == C_REGS*C_PHASES-1);
    endcase
  endfunction

  // style B: optional preamble, five register writes, level-dependent tail
  function automatic rr_word_t seq_b(int lv, int ix);
    int pre, j, g, ph, rg, t;
    pre = (lv == 0) ? 2 : 0;
    if (ix < pre) return mk_word(WK_CMD, (ix == 0) ? 'h5C : 'hC5, 1'b0);
    j = ix - pre;
    if (j < B_REGS*B_PHASES) begin
      g  = j / B_PHASES;
      ph = j % B_PHASES;
      rg = (g < B_REGS-1) ? 4 + g : 'h0D;
      case (ph)
        0:       return mk_word(WK_CMD, 'h55, 1'b0);
        1, 3:    return mk_word(WK_IDLE, 2, 1'b0);
        2:       return mk_word(WK_ADDR, rg, 1'b0);
        default: return mk_word(WK_DATA,
                                (g < B_REGS-1) ? int'(tbl_b(lv, g)) : 0, 1'b0);
      endcase
    end
    t = j - B_REGS*B_PHASES;
    if (lv == EXIT_B) begin
      case (t)
        0:       return mk_word(WK_CMD, 'hFF, 1'b0);
        1:       return mk_word(WK_IDLE, 2, 1'b0);
        default: return mk_word(WK_WAIT, 0, 1'b1);
      endcase
    end
    if (lv == B_EXTRA_LVL) begin
      case (t)
        0:       return mk_word(WK_CMD, 'hB3, 1'b0);
        1:       return mk_word(WK_CMD, 'h26, 1'b0);
        default: return mk_word(WK_CMD, 'h5D, 1'b1);
      endcase
    end
    if (t == 0) return mk_word(WK_CMD, 'h26, 1'b0);
    return mk_word(WK_CMD, 'h5D, 1'b1);
  endfunction

  // style D: opener, register writes, closing opcode
  function automatic rr_word_t seq_d(int lv, int ix);
    int nregs, j, g, ph, rg, dv;
    nregs = (lv == 0) ? D_INIT_REGS : D_REGS;
    if (ix == 0) return mk_word(WK_CMD, 'h3B, 1'b0);
    if (ix == 1) return mk_word(WK_CMD, 'hB9, 1'b0);
    j = ix - 2;
    if (j >= nregs*D_PHASES)
      return mk_word(WK_CMD, (lv == EXIT_D) ? 'hD6 : 'hB6, 1'b1);
    g  = j / D_PHASES;
    ph = j % D_PHASES;
    if (lv == 0)      rg = 4 + g;
    else if (g == 2)  rg = 7;
    else              rg = 4 + g;
    dv = (lv == 0 || lv == EXIT_D) ? 0 : int'(tbl_d(lv, g));
    case (ph)
      0:       return mk_word(WK_CMD, 'h54, 1'b0);
      1:       return mk_word(WK_ADDR, rg, 1'b0);
      default: return mk_word(WK_DATA, dv, 1'b0);
    endcase
  endfunction

  always_comb begin
    case (style)
      STY_A:   word = seq_a(int'(level), int'(idx));
      STY_B:   word = seq_b(int'(level), int'(idx));
      STY_C:   word = seq_c(int'(level), int'(idx));
      STY_D:   word = seq_d(int'(level), int'(idx));
      default: word = mk_word(WK_NONE, 0, 1'b1);
    endcase
  end
endmodule

// File: rtl/rr_cmd_gen.sv
module rr_cmd_gen
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_load,
  input  logic [7:0]       id_byte,
  input  logic             step_req,
  input  logic             word_ready,
  output logic             word_valid,
  output logic [2:0]       word_kind,
  output logic [ARG_W-1:0] word_arg,
  output logic             busy,
  output logic             done,
  output logic [LVL_W-1:0] level
);
  rr_style_e        style;
  logic [LVL_W-1:0] max_lvl;
  logic [IDX_W-1:0] idx_q;
  rr_word_t         wd;
  logic             busy_q, done_q;

  // named events
  logic load_ok, start_seq, quick_done, accept, accept_last;
  assign load_ok     = id_load && !busy_q;
  assign start_seq   = step_req && !busy_q && !id_load && (max_lvl != 0);
  assign quick_done  = step_req && !busy_q && !id_load && (max_lvl == 0);
  assign accept      = busy_q && word_ready;
  assign accept_last = accept && wd.last;

  rr_vendor_map u_map (
    .clk(clk), .rst_n(rst_n), .load_en(load_ok), .id_byte(id_byte),
    .style(style), .max_lvl(max_lvl)
  );

  rr_level_ctr u_lvl (
    .clk(clk), .rst_n(rst_n), .clr(load_ok), .adv(accept_last),
    .max_lvl(max_lvl), .level(level)
  );

  rr_seq_rom u_rom (
    .style(style), .level(level), .idx(idx_q), .word(wd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= accept_last || quick_done;
      if (start_seq) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (accept_last) begin
        busy_q <= 1'b0;
      end else if (accept) begin
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign word_valid = busy_q;
  assign word_kind  = busy_q ? wd.kind : WK_NONE;
  assign word_arg   = busy_q ? wd.arg : '0;

  // R11: a stalled word is held
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=>
      (word_valid && $stable(word_kind) && $stable(word_arg)));

  // R11: completion is only signalled when idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a step during a sequence keeps it running
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_req && !accept_last) |=> busy);

  // R10: disabled retry completes at once without words
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    quick_done |=> (done && !word_valid));
endmodule

// File: tb/rr_cmd_gen_tb_top.sv
module rr_cmd_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id_load = 1'b0;
  logic [7:0] id_byte = 8'h00;
  logic       step_req = 1'b0;
  logic       word_ready = 1'b0;
  logic       word_valid;
  logic [2:0] word_kind;
  logic [7:0] word_arg;
  logic       busy, done;
  logic [4:0] level;

  always #5 clk = ~clk;

  rr_cmd_gen dut_i (
    .clk(clk), .rst_n(rst_n), .id_load(id_load), .id_byte(id_byte),
    .step_req(step_req), .word_ready(word_ready), .word_valid(word_valid),
    .word_kind(word_kind), .word_arg(word_arg), .busy(busy), .done(done),
    .level(level)
  );

  localparam int K_CMD = 1, K_ADR = 2, K_DAT = 3, K_IDL = 4, K_WT = 5;

  logic [7:0] tb_b [32] = '{
    8'h04,8'h04,8'h7C,8'h7E, 8'h00,8'h7C,8'h78,8'h78, 8'h7C,8'h76,8'h74,8'h72,
    8'h08,8'h08,8'h00,8'h00, 8'h0B,8'h7E,8'h76,8'h74, 8'h10,8'h76,8'h72,8'h70,
    8'h02,8'h00,8'h7E,8'h7C, 8'h00,8'h00,8'h00,8'h00};
  logic [7:0] tb_c [60] = '{
    8'h00,8'h00,8'h00,8'h00, 8'h05,8'h0A,8'h00,8'h00, 8'h28,8'h00,8'hEC,8'hD8,
    8'hED,8'hF5,8'hED,8'hE6, 8'h0A,8'h0F,8'h05,8'h00, 8'h0F,8'h0A,8'hFB,8'hEC,
    8'hE8,8'hEF,8'hE8,8'hDC, 8'hF1,8'hFB,8'hFE,8'hF0, 8'h0A,8'h00,8'hFB,8'hEC,
    8'hD0,8'hE2,8'hD0,8'hC2, 8'h14,8'h0F,8'hFB,8'hEC, 8'hE8,8'hFB,8'hE8,8'hDC,
    8'h1E,8'h14,8'hFB,8'hEC, 8'hFB,8'hFF,8'hFB,8'hF8, 8'h07,8'h0C,8'h02,8'h00};
  logic [7:0] tb_d [63] = '{
    8'h00,8'h00,8'h00, 8'hF0,8'hF0,8'hF0, 8'hEF,8'hE0,8'hE0, 8'hDF,8'hD0,8'hD0,
    8'h1E,8'hE0,8'h10, 8'h2E,8'hD0,8'h20, 8'h3D,8'hF0,8'h30, 8'hCD,8'hE0,8'hD0,
    8'h0D,8'hD0,8'h10, 8'h01,8'h10,8'h20, 8'h12,8'h20,8'h20, 8'hB2,8'h10,8'hD0,
    8'hA3,8'h20,8'hD0, 8'h9F,8'h00,8'hD0, 8'hBE,8'hF0,8'hC0, 8'hAD,8'hC0,8'hC0,
    8'h9F,8'hF0,8'hC0, 8'h01,8'h00,8'h00, 8'h02,8'h00,8'h00, 8'h0D,8'hB0,8'h00,
    8'h0C,8'hA0,8'h00};

  int n_chk = 0, n_fail = 0;
  int exp_n, got_n, done_wait, stall_ctr = 0;
  logic [10:0] exp_w [64];
  logic [10:0] got_w [64];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input int k, input int a);
    exp_w[exp_n] = {3'(k), 8'(a)};
    exp_n++;
  endtask

  task automatic build(input int sty, input int lv);
    exp_n = 0;
    case (sty)
      1: begin
        push(K_CMD, 'hEF); push(K_ADR, 'h89); push(K_IDL, 3); push(K_DAT, lv);
        for (int i = 0; i < 3; i++) push(K_DAT, 0);
        push(K_IDL, 2); push(K_WT, 0);
      end
      2: begin
        if (lv == 0) begin push(K_CMD, 'h5C); push(K_CMD, 'hC5); end
        for (int r = 0; r < 5; r++) begin
          push(K_CMD, 'h55); push(K_IDL, 2);
          push(K_ADR, (r == 4) ? 'h0D : 4 + r); push(K_IDL, 2);
          push(K_DAT, (r == 4) ? 0 : int'(tb_b[lv*4 + r]));
        end
        if (lv == 7) begin push(K_CMD, 'hFF); push(K_IDL, 2); push(K_WT, 0); end
        else begin
          if (lv == 6) push(K_CMD, 'hB3);
          push(K_CMD, 'h26); push(K_CMD, 'h5D);
        end
      end
      3: begin
        for (int r = 0; r < 4; r++) begin
          push(K_CMD, 'hA1); push(K_ADR, 0);
          push(K_ADR, (r == 0) ? 'hA7 : 'hA3 + r); push(K_IDL, 2);
          push(K_DAT, int'(tb_c[lv*4 + r])); push(K_IDL, 8);
        end
      end
      default: begin
        push(K_CMD, 'h3B); push(K_CMD, 'hB9);
        if (lv == 0) begin
          for (int r = 4; r <= 12; r++) begin
            push(K_CMD, 'h54); push(K_ADR, r); push(K_DAT, 0);
          end
        end else begin
          for (int r = 0; r < 3; r++) begin
            push(K_CMD, 'h54); push(K_ADR, (r == 2) ? 7 : 4 + r);
            push(K_DAT, (lv == 21) ? 0 : int'(tb_d[lv*3 + r]));
          end
        end
        push(K_CMD, (lv == 21) ? 'hD6 : 'hB6);
      end
    endcase
  endtask

  // issue one step, collect words under a throttled ready, optional mid-run pokes
  task automatic run_step(input bit poke);
    bit held = 0;
    logic [10:0] hw = '0;
    int guard = 0;
    got_n = 0;
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    while (!done && guard < 300) begin
      step_req = 1'b0; id_load = 1'b0;
      if (held) chk({word_kind, word_arg} == hw && word_valid, "R11 hold",
                    int'({word_kind, word_arg}), int'(hw));
      if (poke && got_n == 3) begin
        step_req = 1'b1; id_load = 1'b1; id_byte = 8'h45;
      end
      if (word_valid) begin
        word_ready = (stall_ctr % 3) != 2;
        stall_ctr++;
        if (word_ready) begin
          if (got_n < 64) got_w[got_n] = {word_kind, word_arg};
          got_n++; held = 0;
        end else begin
          held = 1; hw = {word_kind, word_arg};
        end
      end else word_ready = 1'b0;
      @(negedge clk);
      guard++;
    end
    step_req = 1'b0; id_load = 1'b0; word_ready = 1'b0;
    done_wait = guard;
  endtask

  task automatic compare(input string req);
    chk(got_n == exp_n, {req, " word count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_w[i] == exp_w[i], req, int'(got_w[i]), int'(exp_w[i]));
  endtask

  task automatic load_id(input logic [7:0] id);
    id_byte = id; id_load = 1'b1;
    @(negedge clk);
    id_load = 1'b0;
    chk(level == 0, "R12 load clears level", level, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !word_valid && !done, "R1 idle flags", {busy, word_valid, done}, 0);
    chk(word_kind == 0 && level == 0, "R1 kind/level", {word_kind, level}, 0);
  endtask

  task automatic t_vendor(input logic [7:0] id, input int sty, input int mx,
                          input int nsteps, input string req);
    int lv = 0;
    load_id(id);
    for (int s = 0; s < nsteps; s++) begin
      build(sty, lv);
      run_step(1'b0);
      compare(req);
      chk(done, "R11 done after last word", done, 1);
      lv = (lv + 1 == mx) ? 0 : lv + 1;
      chk(level == 5'(lv), "R3 level advance/wrap", level, lv);
      @(negedge clk);
      chk(!done, "R11 done is one pulse", done, 0);
    end
  endtask

  task automatic t_disabled;
    load_id(8'h01);
    run_step(1'b0);
    chk(got_n == 0, "R10 no words", got_n, 0);
    chk(done_wait == 0 && done, "R10 immediate done", done_wait, 0);
    chk(level == 0, "R10 level unchanged", level, 0);
    chk(!busy, "R2 unknown id disables retry", busy, 0);
  endtask

  task automatic t_busy_ignore;
    load_id(8'h2C);
    build(1, 0);
    run_step(1'b1);
    compare("R9 sequence unaffected by pokes");
    @(negedge clk); @(negedge clk);
    chk(!busy && !word_valid, "R9 ignored step did not restart", busy, 0);
    chk(level == 1, "R9 level advanced once", level, 1);
    build(1, 1);
    run_step(1'b0);
    compare("R9 style kept (R4 level 1)");
  endtask

  task automatic t_load_priority;
    load_id(8'h2C);
    build(1, 0); run_step(1'b0);
    build(1, 1); run_step(1'b0);
    chk(level == 2, "R3 level after two steps", level, 2);
    id_byte = 8'h98; id_load = 1'b1; step_req = 1'b1;
    @(negedge clk);
    id_load = 1'b0; step_req = 1'b0;
    chk(!busy && level == 0, "R12 load wins over step", {busy, level}, 0);
    @(negedge clk);
    chk(!done, "R12 dropped step gives no done", done, 0);
    build(2, 0); run_step(1'b0);
    compare("R12 new style B level 0 (R6)");
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      if ($time > 64'd1500000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vendor(8'h2C, 1, 8, 9, "R4 style A");
    t_vendor(8'h98, 2, 8, 9, "R6 R7 style B");
    t_vendor(8'hEC, 3, 15, 16, "R5 style C");
    t_vendor(8'h45, 4, 22, 23, "R8 style D");
    t_disabled();
    t_busy_ignore();
    t_load_priority();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule